// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver with Unanimous Centre Vote

This block takes in bytes of the 8N1 serial format from a single bus line. The line is idle high, and each frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. The block does not make its own baud rate. An external strobe pulses sixteen times per bit period, and the receiver counts these strobes to find the middle of every bit cell.

The bus input first passes through a two-flop synchroniser. A third flop then detects the high-to-low transition that opens a frame. From that point the receiver looks at three samples at the centre of each cell: numbers 7, 8 and 9, counted from 0 at the first strobe after the edge. It does not take a majority of these samples. It accepts a bit as clean only when all three agree. If any cell of a frame has mixed samples, the noise flag is raised for that frame. A start bit whose three centre samples all read high is treated as a glitch and is dropped. A low stop bit raises the framing flag, but the byte is still delivered.

The results are held on the outputs until the next frame completes. A one-cycle valid strobe marks each update. A downstream consumer latches the byte on the strobe and inspects both flags.

Top module: `uart_vote_rx`

## Requirements
- R1: While reset is asserted, and after it is released, the byte output and both error flags read zero and no valid strobe is produced. A reset in the middle of a frame abandons that frame.
- R2: Reception begins only on a high-to-low transition of the synchronised line. A line that stays low after a frame does not start a new one.
- R3: The eight data cells are assembled least significant bit first, so the first data bit on the line appears on bit 0 of the byte output.
- R4: Each completed frame produces exactly one valid strobe, one clock cycle wide. It appears at the centre of the stop bit, 600 to 640 clock cycles after the start edge when the strobe runs every 4 clocks.
- R5: A frame in which every cell has three matching centre samples is reported with the noise flag at 0.
- R6: If the three centre samples of any cell (start, data or stop) disagree, the frame is reported with the noise flag at 1.
- R7: A start bit whose three centre samples all read high is discarded. The receiver returns to idle with no strobe and no change to the outputs.
- R8: If the stop bit centre reads low, the framing flag is 1 and the byte is still presented with a valid strobe. If it reads high, the framing flag is 0.
- R9: The byte output and both flags keep their values between valid strobes.
- R10: The receiver is idle again from the stop bit centre onward, so a frame that starts right at the end of the previous stop cell is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe at sixteen times the bit rate |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe when a frame completes |
| noise_err_o | output | 1 | Centre samples disagreed in some cell of the last frame |
| frame_err_o | output | 1 | Stop bit of the last frame read low |

## Verification
A line edge reaches the edge detector two clocks after it is driven. The start state is entered on the edge after that. The valid strobe then comes 154 strobe periods later, when the stop centre is evaluated, so the bench counts clock cycles from the start edge it drives and accepts the strobe only in the 600 to 640 cycle window. The byte and flags are read at the falling edge after the strobe and compared with values derived from the stimulus vector. The bench places noise glitches exactly one strobe period wide in the middle of a cell, so each glitch corrupts exactly one of the three centre samples.

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx_line,
  output logic [DBITS-1:0] data_o,
  output logic             valid_o,
  output logic             noise_err_o,
  output logic             frame_err_o
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = (DBITS > 1) ? $clog2(DBITS) : 1;
  localparam int S_HI = OVS / 2 + 1;
  localparam logic [CW-1:0] S_LO_C = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] S_HI_C = CW'(S_HI);
  localparam logic [CW-1:0] S_END  = CW'(OVS - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DBITS - 1);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} st_t;

  st_t              st;
  logic             rx_meta, rx_sync, rx_prev;
  logic [CW-1:0]    scnt;
  logic [BW-1:0]    bcnt;
  logic [1:0]       vote;
  logic [DBITS-1:0] shreg;
  logic             noise;

  wire       fall     = rx_prev & ~rx_sync;
  wire       busy     = (st != IDLE);
  wire       at_vote  = busy && tick && scnt >= S_LO_C && scnt < S_HI_C;
  wire       at_eval  = busy && tick && scnt == S_HI_C;
  wire       cell_end = busy && tick && scnt == S_END;
  wire [2:0] trio     = {vote, rx_sync};
  wire       agree    = (&trio) | ~(|trio);
  wire       bit_val  = vote[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_sync <= 1'b1;
      rx_prev <= 1'b1;
    end else begin
      rx_meta <= rx_line;
      rx_sync <= rx_meta;
      rx_prev <= rx_sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      scnt        <= '0;
      bcnt        <= '0;
      vote        <= '0;
      shreg       <= '0;
      noise       <= 1'b0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      noise_err_o <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (st == IDLE) begin
        if (fall) begin
          st    <= START;
          scnt  <= '0;
          bcnt  <= '0;
          noise <= 1'b0;
        end
      end else if (tick) begin
        scnt <= cell_end ? '0 : scnt + 1'b1;
      end

      if (at_vote) vote <= {vote[0], rx_sync};

      if (at_eval) begin
        case (st)
          START: begin
            if (&trio) st <= IDLE;
            else       noise <= noise | ~agree;
          end
          DATA: begin
            shreg <= {bit_val, shreg[DBITS-1:1]};
            noise <= noise | ~agree;
          end
          STOP: begin
            data_o      <= shreg;
            noise_err_o <= noise | ~agree;
            frame_err_o <= ~bit_val;
            valid_o     <= 1'b1;
            st          <= IDLE;
          end
          default: ;
        endcase
      end

      if (cell_end) begin
        case (st)
          START: st <= DATA;
          DATA: begin
            if (bcnt == B_LAST) st <= STOP;
            else                bcnt <= bcnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_vote_rx_chk.sv
module uart_vote_rx_chk #(
  parameter int DBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DBITS-1:0] data_o,
  input logic             valid_o,
  input logic             noise_err_o,
  input logic             frame_err_o
);
  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!valid_o && data_o == '0 && !noise_err_o && !frame_err_o));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(data_o));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(noise_err_o) && $stable(frame_err_o)));
endmodule

bind uart_vote_rx uart_vote_rx_chk #(.DBITS(DBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_o(data_o), .valid_o(valid_o),
  .noise_err_o(noise_err_o), .frame_err_o(frame_err_o)
);

// File: tb/uart_vote_rx_tb_top.sv
module uart_vote_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx_line = 1'b1;
  logic [7:0] data_o;
  logic       valid_o, noise_err_o, frame_err_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int t_start = 0;
  int nval = 0;
  int lat = 0;

  always #2.5 clk = ~clk;

  uart_vote_rx dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line),
    .data_o(data_o), .valid_o(valid_o),
    .noise_err_o(noise_err_o), .frame_err_o(frame_err_o)
  );

  // {byte, noisy cell (15 = none), stop low}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {8'h55, 4'hF, 1'b0},
    {8'hA3, 4'hF, 1'b0},
    {8'h00, 4'hF, 1'b0},
    {8'hFF, 4'hF, 1'b0},
    {8'h81, 4'hF, 1'b1},
    {8'h3C, 4'h0, 1'b0},
    {8'h96, 4'h4, 1'b0},
    {8'h5A, 4'h8, 1'b0}
  };

  initial begin
    int k;
    k = 0;
    forever begin
      @(negedge clk);
      tick = (k == 3);
      k = (k + 1) % 4;
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (valid_o) begin
      nval = nval + 1;
      lat  = cyc - t_start;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic [3:0] ncell,
                      input bit stop_low, input int gap);
    logic [9:0] cells;
    cells = {~stop_low, b, 1'b0};
    @(negedge clk);
    t_start = cyc;
    nval = 0;
    for (int c = 0; c < 10; c++) begin
      for (int i = 0; i < 64; i++) begin
        rx_line = (ncell == 4'(c) && i >= 32 && i < 36) ? ~cells[c] : cells[c];
        @(negedge clk);
      end
    end
    rx_line = 1'b1;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frame_checks(input logic [7:0] b, input bit noisy, input bit stop_low);
    chk(nval == 1, "R4 strobe count", nval, 1);
    chk(lat >= 600 && lat <= 640, "R4 strobe latency", lat, 620);
    if (!noisy) chk(data_o == b, "R3 byte", data_o, b);
    if (noisy) chk(noise_err_o == 1'b1, "R6 noise flag", noise_err_o, 1);
    else       chk(noise_err_o == 1'b0, "R5 noise flag", noise_err_o, 0);
    chk(frame_err_o == stop_low, "R8 framing flag", frame_err_o, stop_low);
  endtask

  initial begin
    idle(5);
    chk(data_o == 8'h00 && !valid_o && !noise_err_o && !frame_err_o,
        "R1 reset state", {data_o, valid_o, noise_err_o, frame_err_o}, 0);
    rst_n = 1'b1;
    idle(20);

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][12:5], VEC[v][4:1], VEC[v][0], 16);
      frame_checks(VEC[v][12:5], VEC[v][4:1] != 4'hF, VEC[v][0]);
    end

    // R7: short low pulse whose centre reads high
    send(8'h6B, 4'hF, 1'b0, 16);
    @(negedge clk);
    t_start = cyc; nval = 0;
    rx_line = 1'b0;
    idle(12);
    rx_line = 1'b1;
    idle(700);
    chk(nval == 0, "R7 glitch strobe", nval, 0);
    chk(data_o == 8'h6B && !noise_err_o && !frame_err_o, "R7 outputs kept", data_o, 8'h6B);
    send(8'hC4, 4'hF, 1'b0, 16);
    frame_checks(8'hC4, 1'b0, 1'b0);

    // R2: line stays low after a low stop bit
    send(8'h27, 4'hF, 1'b1, 0);
    frame_checks(8'h27, 1'b0, 1'b1);
    rx_line = 1'b0;
    nval = 0;
    idle(800);
    chk(nval == 0, "R2 no start without edge", nval, 0);
    chk(data_o == 8'h27 && frame_err_o, "R9 outputs held", data_o, 8'h27);
    rx_line = 1'b1;
    idle(64);
    send(8'h42, 4'hF, 1'b0, 16);
    frame_checks(8'h42, 1'b0, 1'b0);

    // R10: back-to-back frames
    send(8'hE1, 4'hF, 1'b0, 0);
    frame_checks(8'hE1, 1'b0, 1'b0);
    send(8'h1E, 4'hF, 1'b0, 16);
    frame_checks(8'h1E, 1'b0, 1'b0);
    chk(data_o == 8'h1E, "R10 second frame", data_o, 8'h1E);

    // R1: reset in the middle of a frame
    fork
      send(8'hFF, 4'hF, 1'b0, 16);
      begin
        idle(200);
        rst_n = 1'b0;
        idle(3);
        chk(data_o == 8'h00 && !noise_err_o && !frame_err_o, "R1 mid-frame reset",
            data_o, 0);
        rst_n = 1'b1;
      end
    join
    idle(64);
    chk(nval == 0, "R1 frame abandoned", nval, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(100000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule